// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Nesting

This block gathers up to sixteen interrupt requests for a processor core's program sequencer. Request lines arrive asynchronously and are brought into the clock domain by a synchronizer, and a rising edge latches the request. Software can also set or clear any latched request directly. A pending request can be taken only if three conditions hold: its mask bit is one, the global enable is on, and its priority is allowed by the current in-service state. The lowest channel index has the highest priority.

A request is accepted only in a cycle where the sequencer marks an instruction boundary and no delayed-branch slot is in progress. On acceptance the block raises a one-cycle take strobe. That strobe tells the sequencer to push the return address and the status registers. The block then clears the latched bit and marks the level as in service. After a fixed branch delay it presents the vector address, which is the table base plus 32 times the channel index. A return-from-interrupt strobe retires the highest-priority level in service.

With nesting off, nothing is accepted while any level is in service. With nesting on, only a request of strictly higher priority than every level in service can preempt.

Top module: `irqc_ctrl`

## Requirements
- R1: After reset the latch readback, the mask readback, the global enable and the nesting enable are all zero, and neither take_irq nor vec_valid is asserted.
- R2: Suppose a request line rises before clock edge k. Its latch bit then reads one after edge k+2. A line held high does not set the bit again once that bit has been cleared.
- R3: A one on sw_set[i] sets latch bit i at the next edge. A one on sw_clr[i] clears it, and clear wins over set. A request cleared this way is never taken.
- R4: A latched request is taken only when its mask bit is one and the global enable is on. ena_int turns the global enable on, dis_int turns it off, and ctl_we loads both the global enable and the nesting enable.
- R5: When several eligible requests are pending, the one with the lowest channel index is taken first.
- R6: take_irq is asserted only in a cycle where boundary is one and db_busy is zero.
- R7: take_irq lasts one cycle per accepted interrupt and is the push strobe for the return context. After that edge the taken channel's latch bit reads zero.
- R8: vec_valid is high exactly 4 cycles after the take cycle (BRANCH_CYC). At that time vec_addr equals VEC_BASE + 32 × channel index. No other take happens in between.
- R9: With nesting disabled, no request is taken while any level is in service, until rti retires it.
- R10: With nesting enabled, a request is taken while levels are in service only if its index is lower than every in-service index. rti retires the lowest-index in-service level.
- R11: Assume boundary is held high, db_busy is low, the block is otherwise idle, and a line rises before edge k. Then take_irq is high in the cycle following edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| irq_async | input | NUM_IRQ | Asynchronous request lines |
| mask_we | input | 1 | Load mask register |
| mask_wdata | input | NUM_IRQ | Mask data, one enables the channel |
| sw_set | input | NUM_IRQ | Software set of latch bits |
| sw_clr | input | NUM_IRQ | Software clear of latch bits |
| ctl_we | input | 1 | Load control bits |
| ctl_gie | input | 1 | Global enable value for ctl_we |
| ctl_nest | input | 1 | Nesting enable value for ctl_we |
| ena_int | input | 1 | Turn global enable on |
| dis_int | input | 1 | Turn global enable off |
| boundary | input | 1 | Instruction boundary strobe |
| db_busy | input | 1 | Delayed-branch slot in progress |
| rti | input | 1 | Return-from-interrupt strobe |
| take_irq | output | 1 | Interrupt accepted, push return context |
| vec_valid | output | 1 | Vector address ready for fetch |
| vec_addr | output | ADDR_W | Vector address |
| latch_rd | output | NUM_IRQ | Latch register readback |
| mask_rd | output | NUM_IRQ | Mask register readback |

## Verification
The bench targets the following failure modes:
- **Priority:** several requests are raised together under different masks. A reversed or broken priority encoder would return the wrong vector.
- **Latency and vector timing:** the exact edge of take_irq and vec_valid is checked. An extra or missing pipeline stage would shift either one.
- **Acceptance gating:** a held-off boundary, a delayed-branch slot, a cleared global enable and a masked channel are each tried. A design that ignored any one of them would take the interrupt too early.
- **Nesting:** both modes are run. Without nesting, a design that let a higher request preempt would show a take before rti. With nesting, a design that let a lower request in, or that retired the wrong level on rti, would take or block the wrong channel.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Index of the lowest set bit, 32 when none is set.
  function automatic int first_one(input logic [31:0] v);
    int r;
    r = 32;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Levels allowed to be accepted given the in-service set.
  function automatic logic [31:0] eligible_mask(input logic [31:0] isr, input logic nest);
    logic [31:0] r;
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < 32; i++) begin
      seen = seen | isr[i];
      r[i] = nest ? ~seen : (isr == 32'd0);
    end
    return r;
  endfunction

  // Vector address for a channel.
  function automatic logic [31:0] vector_of(input logic [31:0] base, input int idx,
                                            input int stride_log2);
    return base + (32'(idx) << stride_log2);
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] async_in,
  output logic [NUM_IRQ-1:0] rise_out
);
  generate
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
      logic s1_q, s2_q, s3_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
          s3_q <= 1'b0;
        end else begin
          s1_q <= async_in[g];
          s2_q <= s1_q;
          s3_q <= s2_q;
        end
      end
      assign rise_out[g] = s2_q & ~s3_q;
    end
  endgenerate
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] latch,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic [NUM_IRQ-1:0] isr,
  input  logic               gie,
  input  logic               nest,
  output logic               cand_valid,
  output logic [IDX_W-1:0]   cand_idx
);
  logic [31:0] live;
  int          sel;

  always_comb begin
    live = 32'(latch & mask) & eligible_mask(32'(isr), nest) & {32{gie}};
    sel  = first_one(live);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_valid <= 1'b0;
      cand_idx   <= '0;
    end else begin
      cand_valid <= (sel < NUM_IRQ);
      cand_idx   <= IDX_W'(sel);
    end
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int              NUM_IRQ     = 16,
  parameter int              ADDR_W      = 24,
  parameter int              STRIDE_LOG2 = 5,
  parameter int              BRANCH_CYC  = 4,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 24'h001000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_async,
  input  logic               mask_we,
  input  logic [NUM_IRQ-1:0] mask_wdata,
  input  logic [NUM_IRQ-1:0] sw_set,
  input  logic [NUM_IRQ-1:0] sw_clr,
  input  logic               ctl_we,
  input  logic               ctl_gie,
  input  logic               ctl_nest,
  input  logic               ena_int,
  input  logic               dis_int,
  input  logic               boundary,
  input  logic               db_busy,
  input  logic               rti,
  output logic               take_irq,
  output logic               vec_valid,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [NUM_IRQ-1:0] latch_rd,
  output logic [NUM_IRQ-1:0] mask_rd
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int CNT_W = $clog2(BRANCH_CYC + 1);

  logic [NUM_IRQ-1:0] latch_q, mask_q, isr_q;
  logic [NUM_IRQ-1:0] rise, accept_oh, rti_clr;
  logic               gie_q, nest_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  vec_q;
  logic               cand_valid;
  logic [IDX_W-1:0]   cand_idx;
  logic [31:0]        elig_now;
  logic               branch_busy;
  logic               accept;
  logic [IDX_W-1:0]   take_idx;
  int                 rti_lvl;

  irqc_sync #(.NUM_IRQ(NUM_IRQ)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_async), .rise_out(rise)
  );

  irqc_pick #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .latch(latch_q), .mask(mask_q), .isr(isr_q),
    .gie(gie_q), .nest(nest_q), .cand_valid(cand_valid), .cand_idx(cand_idx)
  );

  always_comb begin
    elig_now    = eligible_mask(32'(isr_q), nest_q);
    branch_busy = (cnt_q != '0);
    accept      = boundary & ~db_busy & ~branch_busy & cand_valid & gie_q &
                  latch_q[cand_idx] & mask_q[cand_idx] & elig_now[cand_idx];
    take_idx    = cand_idx;
    accept_oh   = accept ? (NUM_IRQ'(1) << cand_idx) : '0;
    rti_lvl     = first_one(32'(isr_q));
    rti_clr     = (rti && rti_lvl < NUM_IRQ) ? (NUM_IRQ'(1) << rti_lvl) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      mask_q  <= '0;
      isr_q   <= '0;
      gie_q   <= 1'b0;
      nest_q  <= 1'b0;
      cnt_q   <= '0;
      vec_q   <= '0;
    end else begin
      latch_q <= (latch_q | rise | sw_set) & ~sw_clr & ~accept_oh;
      if (mask_we) mask_q <= mask_wdata;
      isr_q <= (isr_q & ~rti_clr) | accept_oh;
      if (ctl_we) begin
        gie_q  <= ctl_gie;
        nest_q <= ctl_nest;
      end
      if (ena_int) gie_q <= 1'b1;
      if (dis_int) gie_q <= 1'b0;
      if (accept) begin
        cnt_q <= CNT_W'(BRANCH_CYC);
        vec_q <= ADDR_W'(vector_of(32'(VEC_BASE), int'(cand_idx), STRIDE_LOG2));
      end else if (branch_busy) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign take_irq  = accept;
  assign vec_valid = (cnt_q == CNT_W'(1));
  assign vec_addr  = vec_q;
  assign latch_rd  = latch_q;
  assign mask_rd   = mask_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ     = 16,
  parameter int ADDR_W      = 24,
  parameter int STRIDE_LOG2 = 5,
  parameter int BRANCH_CYC  = 4,
  parameter int IDX_W       = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               boundary,
  input logic               db_busy,
  input logic               take_irq,
  input logic [IDX_W-1:0]   take_idx,
  input logic               gie_q,
  input logic               nest_q,
  input logic [NUM_IRQ-1:0] isr_q,
  input logic [NUM_IRQ-1:0] mask_q,
  input logic [NUM_IRQ-1:0] latch_q,
  input logic               vec_valid,
  input logic [ADDR_W-1:0]  vec_addr
);
  int          since_take;
  logic [31:0] higher_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_take <= 0;
    else if (take_irq) since_take <= 1;
    else if (since_take != 0 && since_take < BRANCH_CYC) since_take <= since_take + 1;
    else since_take <= 0;
  end

  always_comb higher_busy = ~eligible_mask(32'(isr_q), 1'b1);

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (boundary && !db_busy)); // R6
  AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (gie_q && mask_q[take_idx] && latch_q[take_idx])); // R4
  AST_TAKE_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq); // R7
  AST_NEST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !nest_q) |-> (isr_q == '0)); // R9
  AST_NEST_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && nest_q) |-> !higher_busy[take_idx]); // R10
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[STRIDE_LOG2-1:0] == '0)); // R8
  AST_VEC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (since_take == BRANCH_CYC)); // R8
endmodule

bind irqc_ctrl irqc_checker #(
  .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2),
  .BRANCH_CYC(BRANCH_CYC), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .db_busy(db_busy),
  .take_irq(take_irq), .take_idx(take_idx), .gie_q(gie_q), .nest_q(nest_q),
  .isr_q(isr_q), .mask_q(mask_q), .latch_q(latch_q),
  .vec_valid(vec_valid), .vec_addr(vec_addr)
);

// File: tb/irqc_ctrl_bench.sv
module irqc_ctrl_bench;
  localparam int          N    = 16;
  localparam int          AW   = 24;
  localparam logic [23:0] BASE = 24'h001000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_async = '0, mask_wdata = '0, sw_set = '0, sw_clr = '0;
  logic          mask_we = 0, ctl_we = 0, ctl_gie = 0, ctl_nest = 0;
  logic          ena_int = 0, dis_int = 0, boundary = 0, db_busy = 0, rti = 0;
  logic          take_irq, vec_valid;
  logic [AW-1:0] vec_addr;
  logic [N-1:0]  latch_rd, mask_rd;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqc_ctrl u_irqc_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_async(irq_async), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .sw_set(sw_set), .sw_clr(sw_clr), .ctl_we(ctl_we),
    .ctl_gie(ctl_gie), .ctl_nest(ctl_nest), .ena_int(ena_int), .dis_int(dis_int),
    .boundary(boundary), .db_busy(db_busy), .rti(rti), .take_irq(take_irq),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .latch_rd(latch_rd), .mask_rd(mask_rd)
  );

  // pattern[35:20], mask[19:4], expected channel[3:0]
  localparam logic [35:0] TBL [5] = '{
    {16'h0001, 16'hFFFF, 4'd0},
    {16'h8010, 16'hFFFF, 4'd4},
    {16'h8010, 16'h8000, 4'd15},
    {16'h0300, 16'h02FF, 4'd9},
    {16'hF000, 16'hFFFF, 4'd12}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_take(input int lim, output int cyc);
    cyc = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (take_irq) begin
        cyc = i;
        break;
      end
    end
  endtask

  task automatic pulse_set(input int b);
    sw_set = N'(1) << b; @(negedge clk); sw_set = '0;
  endtask

  task automatic pulse_rti();
    rti = 1; @(negedge clk); rti = 0;
  endtask

  // called in the take cycle; returns the address seen BRANCH_CYC cycles later
  task automatic get_vec(output logic [AW-1:0] a, output bit ok);
    repeat (4) @(negedge clk);
    ok = vec_valid;
    a  = vec_addr;
  endtask

  function automatic logic [AW-1:0] exp_vec(input int ch);
    return BASE + AW'(ch * 32);
  endfunction

  task automatic cleanup(input int rtis);
    irq_async = '0;
    sw_clr = '1; @(negedge clk); sw_clr = '0;
    repeat (rtis) pulse_rti();
    idle(6);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [AW-1:0] a;
    bit ok;

    idle(3);
    // R1 reset state
    check(latch_rd == '0, "R1 latch", latch_rd, 0);
    check(mask_rd == '0, "R1 mask", mask_rd, 0);
    check(!take_irq && !vec_valid, "R1 outputs", {take_irq, vec_valid}, 0);
    rst_n = 1;
    idle(2);
    // R1: a request with global enable still off is not taken
    mask_we = 1; mask_wdata = '1; @(negedge clk); mask_we = 0; boundary = 1;
    pulse_set(3);
    wait_take(6, cyc);
    check(cyc == -1, "R1 gie cleared at reset", cyc, -1);
    cleanup(0);

    // table walk: R5 priority, R8 vector, R11 latency, R7 latch clear
    ena_int = 1; @(negedge clk); ena_int = 0;
    for (int i = 0; i < 5; i++) begin
      logic [15:0] pat, msk;
      int ch;
      pat = TBL[i][35:20]; msk = TBL[i][19:4]; ch = int'(TBL[i][3:0]);
      mask_we = 1; mask_wdata = msk; @(negedge clk); mask_we = 0;
      irq_async = pat;
      wait_take(12, cyc);
      check(cyc == 4, "R11 latency", cyc, 4);
      for (int j = 1; j <= 4; j++) begin
        @(negedge clk);
        if (j == 1) check(latch_rd[ch] == 1'b0, "R7 latch cleared", latch_rd, ch);
        if (j < 4) check(!vec_valid && !take_irq, "R8 quiet branch", {vec_valid, take_irq}, 0);
      end
      check(vec_valid, "R8 vec_valid", vec_valid, 1);
      check(vec_addr == exp_vec(ch), "R5 R8 vector", vec_addr, exp_vec(ch));
      cleanup(1);
    end

    // R4 mask and R2 held level
    mask_we = 1; mask_wdata = '0; @(negedge clk); mask_we = 0;
    irq_async = N'(1) << 6;
    wait_take(8, cyc);
    check(cyc == -1, "R4 masked", cyc, -1);
    check(latch_rd[6], "R2 latched", latch_rd, 16'h0040);
    sw_clr = N'(1) << 6; @(negedge clk); sw_clr = '0;
    idle(3);
    check(latch_rd[6] == 1'b0, "R2 level no reset", latch_rd, 0);
    cleanup(0);

    // R4 global enable
    mask_we = 1; mask_wdata = '1; @(negedge clk); mask_we = 0;
    dis_int = 1; @(negedge clk); dis_int = 0;
    pulse_set(9);
    wait_take(6, cyc);
    check(cyc == -1, "R4 gie off", cyc, -1);
    ena_int = 1; @(negedge clk); ena_int = 0;
    wait_take(4, cyc);
    check(cyc != -1, "R4 gie on", cyc, 1);
    cleanup(1);

    // R6 boundary and delayed branch hold-off
    boundary = 0;
    pulse_set(2);
    wait_take(6, cyc);
    check(cyc == -1, "R6 no boundary", cyc, -1);
    boundary = 1; db_busy = 1;
    wait_take(4, cyc);
    check(cyc == -1, "R6 db slot", cyc, -1);
    @(negedge clk); db_busy = 0; #1;
    check(take_irq, "R6 release", take_irq, 1);
    cleanup(1);

    // R3 software clear cancels
    boundary = 0;
    pulse_set(1);
    idle(1);
    check(latch_rd[1], "R3 sw set", latch_rd, 16'h0002);
    sw_set = N'(1) << 1; sw_clr = N'(1) << 1; @(negedge clk); sw_set = '0; sw_clr = '0;
    check(latch_rd[1] == 1'b0, "R3 clear wins", latch_rd, 0);
    boundary = 1;
    wait_take(5, cyc);
    check(cyc == -1, "R3 cleared not taken", cyc, -1);
    cleanup(0);

    // R9 nesting off
    pulse_set(5);
    wait_take(4, cyc);
    check(cyc != -1, "R9 first take", cyc, 1);
    idle(6);
    pulse_set(2);
    wait_take(8, cyc);
    check(cyc == -1, "R9 no preempt", cyc, -1);
    check(latch_rd[2], "R9 pending kept", latch_rd, 16'h0004);
    pulse_rti();
    wait_take(6, cyc);
    check(cyc != -1, "R9 after rti", cyc, 1);
    get_vec(a, ok);
    check(ok && a == exp_vec(2), "R9 vector", a, exp_vec(2));
    cleanup(1);

    // R10 nesting on
    ctl_we = 1; ctl_gie = 1; ctl_nest = 1; @(negedge clk); ctl_we = 0;
    pulse_set(5);
    wait_take(4, cyc);
    check(cyc != -1, "R10 first take", cyc, 1);
    idle(6);
    pulse_set(7);
    wait_take(8, cyc);
    check(cyc == -1, "R10 lower blocked", cyc, -1);
    pulse_set(2);
    wait_take(4, cyc);
    check(cyc != -1, "R10 higher preempts", cyc, 1);
    get_vec(a, ok);
    check(ok && a == exp_vec(2), "R10 preempt vector", a, exp_vec(2));
    idle(2);
    pulse_rti();
    wait_take(8, cyc);
    check(cyc == -1, "R10 rti retires top only", cyc, -1);
    pulse_rti();
    wait_take(6, cyc);
    check(cyc != -1, "R10 lower after rti", cyc, 1);
    get_vec(a, ok);
    check(ok && a == exp_vec(7), "R10 lower vector", a, exp_vec(7));
    cleanup(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule